// File: doc/BRIEF.md
# Line-Buffer Field Deinterlacer

The block turns a stream of half-field video lines into a progressive stream with twice as many lines. It holds exactly one line in an on-chip line memory. For every incoming line, a scheduler picks one of three actions from the line number and the field flag. The first action passes the line straight through and keeps a copy. The second action blends the line with the kept copy and then replaces the copy with the new line. The third action ignores the incoming data and replays the kept copy.

Each accepted beat carries two RGB pixels of 8 bits per component on a 48-bit bus. The beat also carries its beat index within the line (x), its line number within the field (y) and the field flag. A beat is taken only in a cycle in which the advance strobe is high. For every taken beat the block gives one write strobe to a downstream FIFO, together with the resulting word, exactly two clock cycles later.

Top module: `fld_deint`

## Requirements
- R1: While reset is asserted and after its release, before any beat is taken, `out_wr` is 0 and `out_data` is 0.
- R2: Action codes are A = 2, B = 1, C = 0. With `in_field` = 0, line 0 uses A, line 1 uses C, and from line 2 on an even line uses B and an odd line uses C.
- R3: With `in_field` = 1, line 0 uses A and the last line (y = FIELD_LINES-1) uses C. Every other line uses B when y is odd and C when y is even.
- R4: Action A outputs the input word unchanged and stores it in the line memory at address x.
- R5: Action B outputs, for each 8-bit component, floor((stored + incoming) / 2). Pixel p, component c sits at bits [(3p+c)*8 +: 8]. The incoming word then replaces the stored word at x, even when beats arrive back to back.
- R6: Action C outputs the word stored at x and leaves the line memory unchanged; the incoming data has no effect.
- R7: The average never wraps: 0xFF with 0xFF gives 0xFF, and 0xFF with 0x01 gives 0x80.
- R8: Each beat taken with `adv` high produces exactly one `out_wr` pulse, two cycles later, carrying that beat's result.
- R9: While `adv` is low, no output is written and nothing is stored, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Beat strobe: the inputs below are taken this cycle |
| in_field | input | 1 | Field parity of the current line |
| in_y | input | Y_W (3) | Line number within the field |
| in_x | input | X_W (3) | Beat index within the line (line memory address) |
| in_data | input | 48 | Two packed RGB pixels |
| out_wr | output | 1 | FIFO write strobe |
| out_data | output | 48 | Output word for the FIFO |

## Verification
A wrong schedule decode shows up two cycles after the first beat of the affected line. It appears as a pass-through word where a blend or a replay was expected, and the bench checks each decode over a full field of both parities. A stored line that is corrupted by a write during replay, or a write that is not delayed behind its read, does not show on its own line. It shows on the next B or C line, so the bench streams back-to-back beats and then replays the line. An error in the adder width appears only at saturated or odd component values, so those are driven directly.

// File: rtl/deint_pkg.sv
package deint_pkg;
   typedef enum logic [1:0] {
      ACT_C = 2'd0,
      ACT_B = 2'd1,
      ACT_A = 2'd2
   } action_t;
endpackage

// File: rtl/deint_sched.sv
module deint_sched
   import deint_pkg::*;
#(
   parameter int FIELD_LINES = 6,
   parameter int Y_W         = 3
) (
   input  logic           field,
   input  logic [Y_W-1:0] y,
   output action_t        act
);
   localparam logic [Y_W-1:0] LAST_Y = Y_W'(FIELD_LINES - 1);

   always_comb begin
      if (y == '0) begin
         act = ACT_A;
      end else if (!field) begin
         if (y == Y_W'(1))  act = ACT_C;
         else if (!y[0])    act = ACT_B;
         else               act = ACT_C;
      end else begin
         if (y == LAST_Y)   act = ACT_C;
         else if (y[0])     act = ACT_B;
         else               act = ACT_C;
      end
   end
endmodule

// File: rtl/deint_line_ram.sv
module deint_line_ram #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 48,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             re,
   input  logic [AW-1:0]    ra,
   output logic [WIDTH-1:0] rq,
   input  logic             we,
   input  logic [AW-1:0]    wa,
   input  logic [WIDTH-1:0] wd
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
   end

   always_ff @(posedge clk) begin
      if (re) rq <= mem[ra];
   end
endmodule

// File: rtl/deint_switch.sv
module deint_switch
   import deint_pkg::*;
#(
   parameter int PIX    = 2,
   parameter int NCOMP  = 3,
   parameter int COMP_W = 8,
   localparam int LANES = PIX * NCOMP,
   localparam int DW    = LANES * COMP_W
) (
   input  action_t       act,
   input  logic [DW-1:0] live,
   input  logic [DW-1:0] stored,
   output logic [DW-1:0] res
);
   logic [DW-1:0] blend;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [COMP_W:0] sum;
      assign sum = {1'b0, live[l*COMP_W +: COMP_W]} + {1'b0, stored[l*COMP_W +: COMP_W]};
      assign blend[l*COMP_W +: COMP_W] = sum[COMP_W:1];
   end

   always_comb begin
      unique case (act)
         ACT_A:   res = live;
         ACT_B:   res = blend;
         default: res = stored;
      endcase
   end
endmodule

// File: rtl/fld_deint.sv
module fld_deint
   import deint_pkg::*;
#(
   parameter int PIX_PER_BEAT = 2,
   parameter int NCOMP        = 3,
   parameter int COMP_W       = 8,
   parameter int LINE_BEATS   = 8,
   parameter int FIELD_LINES  = 6,
   parameter int X_W          = $clog2(LINE_BEATS),
   parameter int Y_W          = $clog2(FIELD_LINES),
   localparam int DATA_W      = PIX_PER_BEAT * NCOMP * COMP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              in_field,
   input  logic [Y_W-1:0]    in_y,
   input  logic [X_W-1:0]    in_x,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_wr,
   output logic [DATA_W-1:0] out_data
);
   if (PIX_PER_BEAT < 1 || NCOMP < 1 || COMP_W < 1) begin : g_bad_width
      $error("fld_deint: pixel geometry must be positive");
   end
   if (LINE_BEATS < 2 || (1 << X_W) < LINE_BEATS) begin : g_bad_line
      $error("fld_deint: X_W too narrow for LINE_BEATS");
   end
   if (FIELD_LINES < 3 || (1 << Y_W) < FIELD_LINES) begin : g_bad_field
      $error("fld_deint: FIELD_LINES must be >= 3 and fit in Y_W");
   end

   action_t           sched_act;
   action_t           act_d1;
   logic              vld_d1;
   logic [X_W-1:0]    x_d1;
   logic [DATA_W-1:0] dat_d1;
   logic [DATA_W-1:0] ram_q;
   logic [DATA_W-1:0] sw_res;
   logic              ram_we;

   deint_sched #(.FIELD_LINES(FIELD_LINES), .Y_W(Y_W)) u_sched (
      .field(in_field), .y(in_y), .act(sched_act)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_d1 <= 1'b0;
         act_d1 <= ACT_C;
         x_d1   <= '0;
         dat_d1 <= '0;
      end else begin
         vld_d1 <= adv;
         if (adv) begin
            act_d1 <= sched_act;
            x_d1   <= in_x;
            dat_d1 <= in_data;
         end
      end
   end

   assign ram_we = vld_d1 && (act_d1 != ACT_C);

   deint_line_ram #(.DEPTH(LINE_BEATS), .WIDTH(DATA_W)) u_ram (
      .clk(clk),
      .re(adv), .ra(in_x), .rq(ram_q),
      .we(ram_we), .wa(x_d1), .wd(dat_d1)
   );

   deint_switch #(.PIX(PIX_PER_BEAT), .NCOMP(NCOMP), .COMP_W(COMP_W)) u_switch (
      .act(act_d1), .live(dat_d1), .stored(ram_q), .res(sw_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_wr   <= 1'b0;
         out_data <= '0;
      end else begin
         out_wr <= vld_d1;
         if (vld_d1) out_data <= sw_res;
      end
   end
endmodule

// File: rtl/fld_deint_chk.sv
module fld_deint_chk #(
   parameter int DATA_W      = 48,
   parameter int Y_W         = 3,
   parameter int FIELD_LINES = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adv,
   input logic              in_field,
   input logic [Y_W-1:0]    in_y,
   input logic [DATA_W-1:0] in_data,
   input logic [1:0]        act,
   input logic              out_wr,
   input logic [DATA_W-1:0] out_data
);
   logic [1:0] cyc;
   logic       hist_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end
   assign hist_ok = (cyc >= 2'd2);

   // R8: one write strobe exactly two cycles after each beat, none otherwise (R9)
   a_r8_wr_latency: assert property (@(posedge clk) disable iff (!rst_n)
      hist_ok |-> (out_wr == $past(adv, 2)));

   // R4: pass-through lines reproduce the input word
   a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_ok && out_wr && $past(act, 2) == 2'd2) |-> (out_data == $past(in_data, 2)));

   // R2: field 0 line 1 replays, line 0 passes through
   a_r2_field0_line1: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !in_field && in_y == Y_W'(1)) |-> (act == 2'd0));

   a_r2_first_line: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && in_y == '0) |-> (act == 2'd2));

   // R3: field 1 last line replays
   a_r3_last_line: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && in_field && in_y == Y_W'(FIELD_LINES - 1)) |-> (act == 2'd0));

   // R1: no write strobe straight out of reset
   a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd0) |-> !out_wr);
endmodule

bind fld_deint fld_deint_chk #(
   .DATA_W(PIX_PER_BEAT * NCOMP * COMP_W),
   .Y_W(Y_W),
   .FIELD_LINES(FIELD_LINES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .adv(adv), .in_field(in_field), .in_y(in_y),
   .in_data(in_data), .act(sched_act), .out_wr(out_wr), .out_data(out_data)
);

// File: tb/tb_fld_deint.sv
`timescale 1ns/1ps
module tb_fld_deint;
   localparam int NB = 4;
   localparam int DW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          adv = 1'b0;
   logic          in_field = 1'b0;
   logic [2:0]    in_y = '0;
   logic [2:0]    in_x = '0;
   logic [DW-1:0] in_data = '0;
   logic          out_wr;
   logic [DW-1:0] out_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;
   logic [DW-1:0] ref_mem [8];

   fld_deint dut (
      .clk(clk), .rst_n(rst_n), .adv(adv), .in_field(in_field), .in_y(in_y),
      .in_x(in_x), .in_data(in_data), .out_wr(out_wr), .out_data(out_data)
   );

   always #4 clk = ~clk;

   // {field, y, expected action}: A=2 B=1 C=0
   localparam logic [5:0] VEC [12] = '{
      6'b0_000_10, 6'b0_001_00, 6'b0_010_01, 6'b0_011_00, 6'b0_100_01, 6'b0_101_00,
      6'b1_000_10, 6'b1_001_01, 6'b1_010_00, 6'b1_011_01, 6'b1_100_00, 6'b1_101_00
   };

   function automatic logic [DW-1:0] pat(int y, int x, int s);
      logic [DW-1:0] r;
      for (int c = 0; c < 6; c++) r[c*8 +: 8] = 8'(y*37 + x*91 + c*53 + s*29 + 17);
      return r;
   endfunction

   function automatic logic [DW-1:0] mean(logic [DW-1:0] a, logic [DW-1:0] b);
      logic [DW-1:0] r;
      for (int c = 0; c < 6; c++) r[c*8 +: 8] = 8'((int'(a[c*8 +: 8]) + int'(b[c*8 +: 8])) / 2);
      return r;
   endfunction

   function automatic logic [DW-1:0] expect_of(int act, int x, logic [DW-1:0] d);
      if (act == 2) return d;
      if (act == 1) return mean(ref_mem[x], d);
      return ref_mem[x];
   endfunction

   task automatic check(string req, logic [DW-1:0] act_v, logic [DW-1:0] exp_v);
      n_tests++;
      if (act_v !== exp_v) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act_v, exp_v);
      end
   endtask

   // one isolated beat; checks strobe timing and data
   task automatic beat(string req, bit f, int y, int x, logic [DW-1:0] d, int act);
      logic [DW-1:0] e;
      e = expect_of(act, x, d);
      if (act != 0) ref_mem[x] = d;
      @(negedge clk);
      adv = 1'b1; in_field = f; in_y = 3'(y); in_x = 3'(x); in_data = d;
      @(negedge clk);
      adv = 1'b0; in_data = ~d;
      check({req, " R8 early strobe"}, {47'd0, out_wr}, '0);
      @(negedge clk);
      check({req, " R8 strobe"}, {47'd0, out_wr}, 48'd1);
      check(req, out_data, e);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] sd [NB];
      logic [DW-1:0] se [NB];
      int a;
      repeat (3) @(negedge clk);
      check("R1 reset wr", {47'd0, out_wr}, '0);
      check("R1 reset data", out_data, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after release wr", {47'd0, out_wr}, '0);
      check("R1 after release data", out_data, '0);

      // table walk: full fields of both parities
      for (int v = 0; v < 12; v++) begin
         a = int'(VEC[v][1:0]);
         for (int x = 0; x < NB; x++)
            beat((VEC[v][5] ? "R3 field1" : "R2 field0"), VEC[v][5], int'(VEC[v][4:2]), x,
                 pat(int'(VEC[v][4:2]), x, v), a);
      end

      // R9: idle cycles with garbage must not write or store
      @(negedge clk);
      in_field = 1'b0; in_y = 3'd0; in_x = 3'd1; in_data = '1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check("R9 idle no strobe", {47'd0, out_wr}, '0);
      end
      beat("R9 replay after idle R6", 1'b0, 1, 1, 48'h123456789abc, 0);
      beat("R6 replay ignores data", 1'b0, 3, 1, 48'h0, 0);

      // R7 corner values on address 5
      beat("R7 store ff", 1'b0, 0, 5, {48{1'b1}}, 2);
      beat("R7 ff+ff", 1'b0, 2, 5, {48{1'b1}}, 1);
      beat("R7 ff+01", 1'b0, 4, 5, {6{8'h01}}, 1);
      beat("R5 floor 01+02", 1'b1, 1, 5, {6{8'h02}}, 1);
      beat("R5 replaced then replay", 1'b1, 2, 5, 48'hdeadbeefcafe, 0);

      // R5: back-to-back blend line, then back-to-back replay line
      for (int pass = 0; pass < 2; pass++) begin
         for (int x = 0; x < NB; x++) begin
            sd[x] = pat(7, x, 40 + pass);
            se[x] = expect_of(pass == 0 ? 1 : 0, x, sd[x]);
            if (pass == 0) ref_mem[x] = sd[x];
         end
         for (int k = 0; k < NB + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
               check("R5 stream strobe", {47'd0, out_wr}, 48'd1);
               check(pass == 0 ? "R5 stream blend" : "R5 stream stored R6", out_data, se[k-2]);
            end
            if (k < NB) begin
               adv = 1'b1; in_field = 1'b1; in_y = (pass == 0) ? 3'd3 : 3'd4;
               in_x = 3'(k); in_data = sd[k];
            end else begin
               adv = 1'b0;
            end
         end
      end
      @(negedge clk);
      check("R8 stream end", {47'd0, out_wr}, '0);

      finish_run();
   end
endmodule